// File: doc/BRIEF.md
# Multi-Mode Microcontroller Port Cell

An eight-pin configurable I/O port for a programmable system device that sits on a microcontroller bus. Every pin can be a software-driven I/O bit, carry an output of the logic array, or drive a bit of a bus address byte that was captured on the address-latch strobe. The upper pins can also run open drain. A port-wide mode turns the whole port into a non-multiplexed 8-bit data bus.

Four registers are written over a small internal register bus: a function select, a direction mask, an output data value and a mode word. The pin is modelled as three separate signals: a driven value, an output enable and a sampled level. The sampled level is always passed on to the logic array. Pin outputs, the read-back word and the forwarded input levels are all registered. They reflect a change one clock edge after the register or input that caused it.

Top module: `mcu_port_cell`

## Requirements
- R1: After synchronous reset every register reads 0 and `pin_oe` is 0 (all pins are inputs). Open drain is off, data-port mode is off and the low address byte is selected.
- R2: While `reg_wr` is high at a rising edge, `reg_wdata` loads the register picked by `reg_sel`: 0 function select, 1 direction, 2 output data, 3 mode. Registers 0, 1 and 3 read back their stored value. With `reg_wr` low no register changes.
- R3: A pin whose function bit is 0 takes its enable from its direction bit (1 = drive). With address output off it drives its output-data bit.
- R4: At every rising edge with `ale` high, the address capture register loads `bus_addr[7:0]` if mode bit 0 is 0, or `bus_addr[15:8]` if it is 1. With `ale` low it holds.
- R5: With mode bit 2 set, pins whose function bit is 0 drive the captured address bit of their own index instead of the output-data bit.
- R6: A pin whose function bit is 1 drives `mcell[i]`, and its enable is `pterm[i]`.
- R7: Mode bits 7..4 switch pins 7..4 to open drain. Such a pin drives 0 with its enable set only when the selected value is 0 and its normal enable is 1. Otherwise it is released. Pins 3..0 have no open-drain option.
- R8: With mode bit 1 set the port is a data bus. While `dp_rd` is high all pins drive `dp_rdata`, and otherwise all are released. A rising edge with `dp_wr` high captures `pin_in` into `dp_wdata`. This mode overrides the function, direction and open-drain settings.
- R9: `imc_o` equals `pin_in` from the previous rising edge, in every mode.
- R10: `reg_rdata` is registered from `reg_sel`. Reading register 2 returns, per bit, the output-data bit where the direction bit is 1 and the live `pin_in` level where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read-back data |
| ale | input | 1 | Address latch strobe |
| bus_addr | input | 16 | Microcontroller address bus |
| mcell | input | 8 | Logic-array macrocell outputs |
| pterm | input | 8 | External output-enable product terms |
| dp_rd | input | 1 | Data-port read cycle active |
| dp_wr | input | 1 | Data-port write capture strobe |
| dp_rdata | input | 8 | Data presented on pins in data-port reads |
| dp_wdata | output | 8 | Pin data captured on data-port writes |
| pin_in | input | 8 | Sampled pin levels |
| pin_out | output | 8 | Registered pin drive values |
| pin_oe | output | 8 | Registered pin output enables |
| imc_o | output | 8 | Pin levels forwarded to the logic array |

## Verification
The output mux is tried with mixed function masks, where one half comes from macrocells and the other from the output register, so that a swapped source or enable shows up as a wrong nibble. Address output is tried with an address whose two bytes differ. A strobe-free address change follows, which separates latching from pass-through and low byte from high byte. Open drain is tried with a value that alternates 0 and 1 across the upper nibble, which separates released pins from pins driven low. Read-back of the data register uses a split direction mask, so that the register half and the live-pin half are told apart.

// File: rtl/port_cell_pkg.sv
package port_cell_pkg;

  typedef enum logic [1:0] {
    SEL_FUNC = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DOUT = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  localparam int MODE_ADDR_HI   = 0;
  localparam int MODE_DATA_PORT = 1;
  localparam int MODE_ADDR_OUT  = 2;

endpackage

// File: rtl/port_regs.sv
module port_regs
  import port_cell_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sel,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] func_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] rdata
);

  logic [W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      func_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      mode_q <= '0;
    end else if (wr) begin
      case (reg_sel_e'(sel))
        SEL_FUNC: func_q <= wdata;
        SEL_DIR:  dir_q  <= wdata;
        SEL_DOUT: dout_q <= wdata;
        SEL_MODE: mode_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(sel))
      SEL_FUNC: rd_next = func_q;
      SEL_DIR:  rd_next = dir_q;
      SEL_DOUT: rd_next = (dout_q & dir_q) | (pin_in & ~dir_q);
      SEL_MODE: rd_next = mode_q;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

endmodule

// File: rtl/port_addr_latch.sv
module port_addr_latch #(
  parameter int W  = 8,
  parameter int AW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ale,
  input  logic          hi_sel,
  input  logic [AW-1:0] bus_addr,
  output logic [W-1:0]  alat
);

  logic [W-1:0] byte_pick;

  assign byte_pick = hi_sel ? bus_addr[2*W-1:W] : bus_addr[W-1:0];

  always_ff @(posedge clk) begin
    if (rst)      alat <= '0;
    else if (ale) alat <= byte_pick;
  end

endmodule

// File: rtl/port_pin_slice.sv
module port_pin_slice (
  input  logic func_alt,
  input  logic dir_bit,
  input  logic dout_bit,
  input  logic addr_bit,
  input  logic addr_out,
  input  logic mcell_bit,
  input  logic pterm_bit,
  input  logic od_en,
  output logic drv,
  output logic en
);

  logic src;
  logic en_raw;

  always_comb begin
    if (func_alt) src = mcell_bit;
    else if (addr_out) src = addr_bit;
    else src = dout_bit;
    en_raw = func_alt ? pterm_bit : dir_bit;
    if (od_en) begin
      drv = 1'b0;
      en  = en_raw & ~src;
    end else begin
      drv = src;
      en  = en_raw;
    end
  end

endmodule

// File: rtl/mcu_port_cell.sv
module mcu_port_cell
  import port_cell_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 2 * W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          ale,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  mcell,
  input  logic [W-1:0]  pterm,
  input  logic          dp_rd,
  input  logic          dp_wr,
  input  logic [W-1:0]  dp_rdata,
  output logic [W-1:0]  dp_wdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  imc_o
);

  localparam int OD_LO = W / 2;

  logic [W-1:0] func_q, dir_q, dout_q, mode_q;
  logic [W-1:0] alat;
  logic [W-1:0] od_vec;
  logic [W-1:0] slice_drv, slice_en;
  logic [W-1:0] out_next, oe_next;
  logic         data_port;

  assign data_port = mode_q[MODE_DATA_PORT];

  port_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .sel    (reg_sel),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .pin_in (pin_in),
    .func_q (func_q),
    .dir_q  (dir_q),
    .dout_q (dout_q),
    .mode_q (mode_q),
    .rdata  (reg_rdata)
  );

  port_addr_latch #(.W(W), .AW(AW)) u_alat (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale),
    .hi_sel   (mode_q[MODE_ADDR_HI]),
    .bus_addr (bus_addr),
    .alat     (alat)
  );

  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i >= OD_LO) begin : g_od
      assign od_vec[i] = mode_q[i];
    end else begin : g_pp
      assign od_vec[i] = 1'b0;
    end

    port_pin_slice u_slice (
      .func_alt  (func_q[i]),
      .dir_bit   (dir_q[i]),
      .dout_bit  (dout_q[i]),
      .addr_bit  (alat[i]),
      .addr_out  (mode_q[MODE_ADDR_OUT]),
      .mcell_bit (mcell[i]),
      .pterm_bit (pterm[i]),
      .od_en     (od_vec[i]),
      .drv       (slice_drv[i]),
      .en        (slice_en[i])
    );
  end

  always_comb begin
    if (data_port) begin
      out_next = dp_rdata;
      oe_next  = {W{dp_rd}};
    end else begin
      out_next = slice_drv;
      oe_next  = slice_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out  <= '0;
      pin_oe   <= '0;
      imc_o    <= '0;
      dp_wdata <= '0;
    end else begin
      pin_out <= out_next;
      pin_oe  <= oe_next;
      imc_o   <= pin_in;
      if (data_port && dp_wr) dp_wdata <= pin_in;
    end
  end

endmodule

// File: rtl/port_cell_checker.sv
module port_cell_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] func_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] mode_q,
  input logic [W-1:0] alat,
  input logic [W-1:0] mcell,
  input logic [W-1:0] pin_in,
  input logic         ale,
  input logic         dp_rd,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] imc_o
);

  localparam int OD_LO = W / 2;

  logic [W-1:0] od_mask;
  logic         dp;

  assign od_mask = {mode_q[W-1:OD_LO], {OD_LO{1'b0}}};
  assign dp      = mode_q[1];

  p_released_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pin_oe == '0);

  p_dir_enable_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(dp) |-> ((pin_oe ^ $past(dir_q)) & $past(~func_q & ~od_mask)) == '0);

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(alat));

  p_mcell_source_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(dp) |-> ((pin_out ^ $past(mcell)) & $past(func_q & ~od_mask)) == '0);

  p_od_never_high_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(dp) |-> (pin_out & pin_oe & $past(od_mask)) == '0);

  p_bus_drive_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(dp) && $past(dp_rd)) |-> pin_oe == '1);

  p_bus_release_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(dp) && !$past(dp_rd)) |-> pin_oe == '0);

  p_imc_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> imc_o == $past(pin_in));

endmodule

bind mcu_port_cell port_cell_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .func_q  (func_q),
  .dir_q   (dir_q),
  .mode_q  (mode_q),
  .alat    (alat),
  .mcell   (mcell),
  .pin_in  (pin_in),
  .ale     (ale),
  .dp_rd   (dp_rd),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .imc_o   (imc_o)
);

// File: tb/mcu_port_cell_test.sv
`timescale 1ns/1ps
module mcu_port_cell_test;

  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    reg_sel = '0;
  logic          reg_wr = 1'b0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          ale = 1'b0;
  logic [2*W-1:0] bus_addr = '0;
  logic [W-1:0]  mcell = '0, pterm = '0, dp_rdata = '0, pin_in = '0;
  logic          dp_rd = 1'b0, dp_wr = 1'b0;
  logic [W-1:0]  dp_wdata, pin_out, pin_oe, imc_o;

  always #2.5 clk = ~clk;

  mcu_port_cell #(.W(W)) uut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ale(ale),
    .bus_addr(bus_addr), .mcell(mcell), .pterm(pterm), .dp_rd(dp_rd),
    .dp_wr(dp_wr), .dp_rdata(dp_rdata), .dp_wdata(dp_wdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .imc_o(imc_o)
  );

  typedef enum int {K_OUT, K_OE, K_RD, K_IMC, K_DPW} kind_e;
  typedef struct {
    kind_e      kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        K_OUT:   act = pin_out;
        K_OE:    act = pin_oe;
        K_RD:    act = reg_rdata;
        K_IMC:   act = imc_o;
        default: act = dp_wdata;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: %s actual=%02h expected=%02h", it.tag, it.kind.name(), act, it.exp);
      end
    end
  end

  task automatic expect_val(kind_e k, logic [7:0] e, string tag);
    item_t it;
    repeat (2) @(posedge clk);
    it.kind = k; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #0.5;
  endtask

  task automatic wr_reg(logic [1:0] s, logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] s, logic [7:0] e, string tag);
    @(negedge clk);
    reg_sel = s;
    expect_val(K_RD, e, tag);
  endtask

  task automatic ale_pulse(logic [15:0] a);
    @(negedge clk);
    bus_addr = a; ale = 1'b1;
    @(negedge clk);
    ale = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    expect_val(K_OE, 8'h00, "R1 oe after reset");
    rd_reg(2'd0, 8'h00, "R1 func reg");
    rd_reg(2'd1, 8'h00, "R1 dir reg");
    rd_reg(2'd3, 8'h00, "R1 mode reg");

    // R2 register writes and read-back
    wr_reg(2'd0, 8'hA5);
    rd_reg(2'd0, 8'hA5, "R2 func readback");
    wr_reg(2'd1, 8'h3C);
    rd_reg(2'd1, 8'h3C, "R2 dir readback");
    @(negedge clk); reg_sel = 2'd1; reg_wdata = 8'hFF; reg_wr = 1'b0;
    rd_reg(2'd1, 8'h3C, "R2 no write without strobe");
    wr_reg(2'd0, 8'h00);

    // R3 software I/O
    wr_reg(2'd1, 8'h0F);
    wr_reg(2'd2, 8'h55);
    expect_val(K_OUT, 8'h55, "R3 drive data bits");
    expect_val(K_OE, 8'h0F, "R3 enable from direction");

    // R10 data read mixes register and live pins
    pin_in = 8'hA0;
    rd_reg(2'd2, 8'hA5, "R10 data readback");

    // R9 forwarding
    pin_in = 8'h3C;
    expect_val(K_IMC, 8'h3C, "R9 pin forward");

    // R4 / R5 address output
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd3, 8'h04);
    ale_pulse(16'h12C7);
    expect_val(K_OUT, 8'hC7, "R5 low address byte on pins");
    expect_val(K_OE, 8'hFF, "R5 enable from direction");
    @(negedge clk); bus_addr = 16'hFFFF;
    expect_val(K_OUT, 8'hC7, "R4 hold without strobe");
    wr_reg(2'd3, 8'h05);
    ale_pulse(16'h12C7);
    expect_val(K_OUT, 8'h12, "R4 high address byte");

    // R6 macrocell outputs with product-term enables
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'hF0);
    wr_reg(2'd1, 8'h0F);
    @(negedge clk); mcell = 8'h9A; pterm = 8'h30;
    expect_val(K_OUT, 8'h95, "R6 macrocell source");
    expect_val(K_OE, 8'h3F, "R6 product term enable");

    // R7 open drain on upper pins
    wr_reg(2'd0, 8'h00);
    wr_reg(2'd1, 8'hFF);
    wr_reg(2'd2, 8'h5A);
    wr_reg(2'd3, 8'hF0);
    expect_val(K_OUT, 8'h0A, "R7 open drain drives only low");
    expect_val(K_OE, 8'hAF, "R7 released where value is one");

    // R8 data-port mode
    wr_reg(2'd3, 8'h02);
    @(negedge clk); dp_rd = 1'b1; dp_rdata = 8'h6E;
    expect_val(K_OUT, 8'h6E, "R8 bus read data on pins");
    expect_val(K_OE, 8'hFF, "R8 all pins drive on read");
    @(negedge clk); dp_rd = 1'b0;
    expect_val(K_OE, 8'h00, "R8 released outside read");
    @(negedge clk); pin_in = 8'hB4; dp_wr = 1'b1;
    @(negedge clk); dp_wr = 1'b0; pin_in = 8'h11;
    expect_val(K_DPW, 8'hB4, "R8 write capture");
    expect_val(K_IMC, 8'h11, "R9 forward in data-port mode");
    rd_reg(2'd3, 8'h02, "R2 mode readback");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule